// File: doc/BRIEF.md
# Serial Character Buffer Registers

This block is the register pair between a processor bus and a serial shift engine. On the transmit side, the processor writes a character of up to nine bits into a write-only holding register. Writing the low byte announces the character to the transmitter with a one-cycle valid pulse. On the receive side, the shift engine hands over each finished character with a single-cycle completion strobe. The strobe carries the nine data bits and the framing and parity indications. The block stores these in a read-only buffer, together with an overrun flag and a summary error flag.

The bus is byte-addressed through a two-bit offset:

| Offset | Register |
|--------|----------|
| 0 | Transmit bits 7..0 |
| 1 | Transmit bit 8, in write-data bit 0 |
| 2 | Received bits 7..0 |
| 3 | Received status byte |

Read data is combinational while the read strobe is high, and 0 otherwise. The status byte holds, from bit 7 down:

| Bit | Content |
|-----|---------|
| 7 | Summary error |
| 6 | Parity error |
| 5 | Framing error |
| 4 | Overrun |
| 3..1 | Zero |
| 0 | Received bit 8 |

A 3-bit mode input and a receiver-enable input control how the flags behave. Mode 000 means the interface is off, and mode 001 means clock-synchronous operation; every other mode is asynchronous.

Top module: `uart_bufregs`

## Requirements
- R1: A bus write to offset 0 places write data in txData[7:0] after that clock edge. txValid is high for exactly the one cycle that follows.
- R2: A bus write to offset 1 sets txData[8] from write-data bit 0. Write-data bits 7..1 are ignored, and this write raises no txValid pulse.
- R3: Bus reads of offsets 0 and 1 return 0.
- R4: A completion strobe that arrives while the receiver is active and no unread character is held loads the character. A read of offset 2 then returns bits 7..0, and status bit 0 returns bit 8 with status bits 3..1 at 0.
- R5: The completion strobe loads the framing flag (status bit 5) and parity flag (status bit 6) from the shifter's indications. Status bit 7 is the OR of bits 6..4.
- R6: Reading offset 2 clears the framing and parity flags from the next cycle. Reading offset 3 clears nothing.
- R7: A completion strobe that arrives while the stored character is unread sets the overrun flag (status bit 4). The stored data and the stored framing and parity flags are kept.
- R8: Reading offset 2 clears the overrun flag only if the most recent accepted strobe was not itself an overrun.
- R9: If a completion strobe coincides with a read of offset 2, the read returns the old character. The new character and its flags are then stored, and no overrun is raised.
- R10: While mode is 000 or receiver-enable is 0, status bits 7..4 read 0 and the stored flags are cleared. Completion strobes are ignored, and the stored data is kept.
- R11: In mode 001, status bits 7..5 read 0 and the framing and parity indications are not stored. The overrun flag still operates.
- R12: After reset, txData and txValid are 0, and reads of offsets 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Byte offset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid while busRe is high |
| rxDone | input | 1 | Character-complete strobe from the shifter |
| rxData | input | 9 | Received character |
| rxFrameErr | input | 1 | Framing error indication with rxDone |
| rxParityErr | input | 1 | Parity error indication with rxDone |
| modeSel | input | 3 | Mode: 000 off, 001 synchronous, others asynchronous |
| rxEnable | input | 1 | Receiver enable |
| txData | output | 9 | Transmit character toward the shifter |
| txValid | output | 1 | One-cycle pulse after a low-byte transmit write |

## Verification
Read data is combinational, so the bench samples busRdata 1 ns after raising the strobes, in the same cycle as the read. Any clear caused by that read is observed only through a further read, issued from the following falling edge onward. Writes and completion strobes take effect at the next rising edge. The bench therefore checks txData, txValid and the stored flags at the falling edge that follows. It checks txValid once more a full cycle later, to show that the pulse has ended. Mode and enable masking are combinational and are checked in the cycle they change, and again after a return to asynchronous mode, to show that the stored flags were cleared.

// File: rtl/uart_bufregs_pkg.sv
package uart_bufregs_pkg;
  localparam int BYTE_W = 8;
  localparam int CHAR_W = 9;
  localparam int HI_W = CHAR_W - BYTE_W;
  localparam int ADDR_W = 2;
  localparam int PAD_W = BYTE_W - 4 - HI_W;

  localparam logic [ADDR_W-1:0] OFS_TX_LO = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_TX_HI = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_RX_LO = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_RX_HI = 2'd3;

  localparam logic [2:0] MODE_OFF = 3'b000;
  localparam logic [2:0] MODE_SYNC = 3'b001;

  typedef struct packed {
    logic txLoWr;
    logic txHiWr;
    logic loadChar;
    logic markOvr;
    logic clrFerPer;
    logic clrOer;
    logic clrAll;
    logic syncMode;
    logic rxActive;
  } bufStrobe_t;
endpackage

// File: rtl/uart_bufregs_ctrl.sv
module uart_bufregs_ctrl
  import uart_bufregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              rxDone,
  input  logic [2:0]        modeSel,
  input  logic              rxEnable,
  output bufStrobe_t        strobe
);
  logic unread;
  logic lastOvr;
  logic active;
  logic loRead;
  logic ovrNow;
  logic takeNow;

  assign active  = (modeSel != MODE_OFF) && rxEnable;
  assign loRead  = busRe && (busAddr == OFS_RX_LO);
  // a coincident low read consumes the old character first
  assign ovrNow  = rxDone && active && unread && !loRead;
  assign takeNow = rxDone && active && !ovrNow;

  always_comb begin
    strobe.txLoWr    = busWe && (busAddr == OFS_TX_LO);
    strobe.txHiWr    = busWe && (busAddr == OFS_TX_HI);
    strobe.loadChar  = takeNow;
    strobe.markOvr   = ovrNow;
    strobe.clrFerPer = loRead;
    strobe.clrOer    = loRead && !lastOvr;
    strobe.clrAll    = !active;
    strobe.syncMode  = (modeSel == MODE_SYNC);
    strobe.rxActive  = active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unread  <= 1'b0;
      lastOvr <= 1'b0;
    end else if (!active) begin
      unread  <= 1'b0;
      lastOvr <= 1'b0;
    end else begin
      if (takeNow || ovrNow) unread <= 1'b1;
      else if (loRead)       unread <= 1'b0;
      if (ovrNow)            lastOvr <= 1'b1;
      else if (takeNow)      lastOvr <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_bufregs_dp.sv
module uart_bufregs_dp
  import uart_bufregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRe,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  output logic [BYTE_W-1:0] busRdata,
  output logic [CHAR_W-1:0] txData,
  output logic              txValid
);
  logic [CHAR_W-1:0] txBuf;
  logic [CHAR_W-1:0] rxBuf;
  logic fer, per, oer;
  logic ferView, perView, oerView, sumView;
  logic [BYTE_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txValid <= 1'b0;
    end else begin
      txValid <= strobe.txLoWr;
      if (strobe.txLoWr) txBuf[BYTE_W-1:0] <= busWdata;
      if (strobe.txHiWr) txBuf[CHAR_W-1:BYTE_W] <= busWdata[HI_W-1:0];
    end
  end
  assign txData = txBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0;
    end else if (strobe.loadChar) begin
      rxBuf <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fer <= 1'b0;
      per <= 1'b0;
      oer <= 1'b0;
    end else if (strobe.clrAll) begin
      fer <= 1'b0;
      per <= 1'b0;
      oer <= 1'b0;
    end else begin
      if (strobe.loadChar) begin
        fer <= rxFrameErr && !strobe.syncMode;
        per <= rxParityErr && !strobe.syncMode;
      end else if (strobe.clrFerPer) begin
        fer <= 1'b0;
        per <= 1'b0;
      end
      if (strobe.markOvr)     oer <= 1'b1;
      else if (strobe.clrOer) oer <= 1'b0;
    end
  end

  assign oerView = oer && strobe.rxActive;
  assign ferView = fer && strobe.rxActive && !strobe.syncMode;
  assign perView = per && strobe.rxActive && !strobe.syncMode;
  assign sumView = !strobe.syncMode && (oerView || ferView || perView);
  assign statusByte = {sumView, perView, ferView, oerView, {PAD_W{1'b0}},
                       rxBuf[CHAR_W-1:BYTE_W]};

  always_comb begin
    busRdata = '0;
    if (busRe) begin
      case (busAddr)
        OFS_RX_LO: busRdata = rxBuf[BYTE_W-1:0];
        OFS_RX_HI: busRdata = statusByte;
        default:   busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_bufregs.sv
module uart_bufregs
  import uart_bufregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              rxDone,
  input  logic [CHAR_W-1:0] rxData,
  input  logic              rxFrameErr,
  input  logic              rxParityErr,
  input  logic [2:0]        modeSel,
  input  logic              rxEnable,
  output logic [CHAR_W-1:0] txData,
  output logic              txValid
);
  bufStrobe_t strobe;

  uart_bufregs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .rxDone(rxDone), .modeSel(modeSel), .rxEnable(rxEnable), .strobe(strobe)
  );

  uart_bufregs_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr), .busRe(busRe),
    .busWdata(busWdata), .rxData(rxData), .rxFrameErr(rxFrameErr),
    .rxParityErr(rxParityErr), .busRdata(busRdata), .txData(txData),
    .txValid(txValid)
  );
endmodule

// File: rtl/uart_bufregs_chk.sv
module uart_bufregs_chk
  import uart_bufregs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [BYTE_W-1:0] busWdata,
  input logic [BYTE_W-1:0] busRdata,
  input logic [2:0]        modeSel,
  input logic              rxEnable,
  input logic              rxDone,
  input logic [CHAR_W-1:0] txData,
  input logic              txValid
);
  logic hiRead;
  assign hiRead = busRe && (busAddr == OFS_RX_HI);

  a_r1_low_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_TX_LO) |=> (txValid && txData[BYTE_W-1:0] == $past(busWdata)));

  a_r2_high_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_TX_HI) |=> (txData[CHAR_W-1:BYTE_W] == $past(busWdata[HI_W-1:0]) && !txValid));

  a_r3_tx_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && (busAddr == OFS_TX_LO || busAddr == OFS_TX_HI)) |-> busRdata == '0);

  a_r5_sum_is_or: assert property (@(posedge clk) disable iff (!rstN)
    (hiRead && modeSel != MODE_SYNC) |-> (busRdata[7] == (|busRdata[6:4])));

  a_r6_low_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == OFS_RX_LO && !rxDone) |=> (!hiRead || busRdata[6:5] == 2'b00));

  a_r10_disabled_masks: assert property (@(posedge clk) disable iff (!rstN)
    (hiRead && (modeSel == MODE_OFF || !rxEnable)) |-> busRdata[7:4] == 4'h0);

  a_r11_sync_masks: assert property (@(posedge clk) disable iff (!rstN)
    (hiRead && modeSel == MODE_SYNC) |-> busRdata[7:5] == 3'b000);
endmodule

bind uart_bufregs uart_bufregs_chk u_chk (.*);

// File: tb/sim_uart_bufregs.sv
module sim_uart_bufregs;
  localparam time CLK_PERIOD = 10ns;
  localparam int NVEC = 11;
  localparam logic [1:0] OP_WR = 2'd1, OP_RD = 2'd2, OP_TX = 2'd3;

  // {op, addr, data, expected}
  localparam logic [20:0] VEC [NVEC] = '{
    {OP_WR, 2'd0, 8'hA5, 9'h000},  // R1
    {OP_TX, 2'd0, 8'h00, 9'h0A5},  // R1
    {OP_WR, 2'd1, 8'hFF, 9'h000},  // R2: only bit 0 counts
    {OP_TX, 2'd0, 8'h00, 9'h1A5},  // R2
    {OP_RD, 2'd0, 8'h00, 9'h000},  // R3
    {OP_RD, 2'd1, 8'h00, 9'h000},  // R3
    {OP_WR, 2'd0, 8'h3C, 9'h000},  // R1
    {OP_TX, 2'd0, 8'h00, 9'h13C},  // R1
    {OP_WR, 2'd1, 8'hFE, 9'h000},  // R2
    {OP_TX, 2'd0, 8'h00, 9'h03C},  // R2
    {OP_RD, 2'd1, 8'h00, 9'h000}   // R3
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWe = 1'b0, busRe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic rxDone = 1'b0, rxFrameErr = 1'b0, rxParityErr = 1'b0;
  logic [8:0] rxData = '0;
  logic [2:0] modeSel = 3'b010;
  logic rxEnable = 1'b1;
  logic [8:0] txData;
  logic txValid;
  int checks = 0, errors = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bufregs u0 (.*);

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic rxChar(input logic [8:0] d, input logic fe, input logic pe);
    rxData = d; rxFrameErr = fe; rxParityErr = pe; rxDone = 1'b1;
    @(negedge clk);
    rxDone = 1'b0;
  endtask

  task automatic expRead(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] v;
    busRead(a, v);
    check(req, {1'b0, v}, {1'b0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 txData", txData, 9'h000);
    check("R12 txValid", {8'h0, txValid}, 9'h000);
    expRead("R12 rx low", 2'd2, 8'h00);
    expRead("R12 status", 2'd3, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][20:19])
        OP_WR: begin
          busWrite(VEC[i][18:17], VEC[i][16:9]);
          if (VEC[i][18:17] == 2'd0) check("R1 pulse high", {8'h0, txValid}, 9'h001);
          else check("R2 no pulse", {8'h0, txValid}, 9'h000);
        end
        OP_RD: begin
          busRead(VEC[i][18:17], rd);
          check("R3 tx read", {1'b0, rd}, VEC[i][8:0]);
        end
        default: begin
          check("R1/R2 txData", txData, VEC[i][8:0]);
          @(negedge clk);
          check("R1 pulse ends", {8'h0, txValid}, 9'h000);
        end
      endcase
    end

    // R4 plain capture
    rxChar(9'h15A, 1'b0, 1'b0);
    expRead("R4 status d8", 2'd3, 8'h01);
    expRead("R4 low byte", 2'd2, 8'h5A);
    // R5 framing, R6 clear
    rxChar(9'h033, 1'b1, 1'b0);
    expRead("R5 framing", 2'd3, 8'hA0);
    expRead("R5 data", 2'd2, 8'h33);
    expRead("R6 cleared", 2'd3, 8'h00);
    // R5 parity, R6 high read keeps
    rxChar(9'h044, 1'b0, 1'b1);
    expRead("R5 parity", 2'd3, 8'hC0);
    expRead("R6 high read keeps", 2'd3, 8'hC0);
    expRead("R6 data", 2'd2, 8'h44);
    expRead("R6 cleared parity", 2'd3, 8'h00);
    // R7 overrun, R8 clearing rule
    rxChar(9'h011, 1'b0, 1'b0);
    rxChar(9'h022, 1'b1, 1'b1);
    expRead("R7 overrun flag", 2'd3, 8'h90);
    expRead("R7 data kept", 2'd2, 8'h11);
    expRead("R8 overrun stays", 2'd3, 8'h90);
    rxChar(9'h055, 1'b0, 1'b0);
    expRead("R8 before read", 2'd3, 8'h90);
    expRead("R8 data", 2'd2, 8'h55);
    expRead("R8 overrun cleared", 2'd3, 8'h00);
    // R9 coincident strobe and low read
    rxChar(9'h066, 1'b1, 1'b0);
    busAddr = 2'd2; busRe = 1'b1;
    rxData = 9'h077; rxFrameErr = 1'b0; rxParityErr = 1'b1; rxDone = 1'b1;
    #1 rd = busRdata;
    @(negedge clk);
    busRe = 1'b0; rxDone = 1'b0;
    check("R9 old data read", {1'b0, rd}, 9'h066);
    expRead("R9 new flags", 2'd3, 8'hC0);
    expRead("R9 new data", 2'd2, 8'h77);
    expRead("R9 cleared", 2'd3, 8'h00);
    // R11 synchronous mode
    modeSel = 3'b001;
    rxChar(9'h088, 1'b1, 1'b1);
    expRead("R11 no async flags", 2'd3, 8'h00);
    rxChar(9'h099, 1'b0, 1'b0);
    expRead("R11 overrun only", 2'd3, 8'h10);
    expRead("R11 data kept", 2'd2, 8'h88);
    modeSel = 3'b010;
    expRead("R11 back to async", 2'd3, 8'h90);
    // R10 receiver disabled
    rxEnable = 1'b0;
    expRead("R10 masked", 2'd3, 8'h00);
    rxChar(9'h0AA, 1'b1, 1'b1);
    rxEnable = 1'b1;
    expRead("R10 flags cleared", 2'd3, 8'h00);
    expRead("R10 strobe ignored", 2'd2, 8'h88);
    // R10 interface off
    rxChar(9'h0BB, 1'b1, 1'b0);
    modeSel = 3'b000;
    expRead("R10 off masked", 2'd3, 8'h00);
    modeSel = 3'b010;
    expRead("R10 off cleared", 2'd3, 8'h00);
    expRead("R10 data kept", 2'd2, 8'hBB);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule